// File: doc/BRIEF.md
# Dual-Rail Precharged AND Lane Array

This block computes a bitwise AND of two single-rail operand words using a dual-rail, return-to-zero style. Every logical bit travels as a complementary pair of wires, a true rail and a false rail. The pair (1,0) means logic one, (0,1) means logic zero, and (0,0) is the spacer that every pair returns to between data items. A phase register alternates between a precharge cycle and an evaluation cycle. During evaluation, each of the parallel lanes presents exactly one high rail at its output. The number of rail transitions per operation therefore does not depend on the operand values.

Operands are registered at the clock edge that ends a precharge cycle. They are converted into rail pairs, and the phase gates them to the spacer at the very first combinational stage. Every later gate then inherits the spacer. Each lane uses only AND on the true rails and OR on the false rails. Output registers capture the lane rails on every edge: data after an evaluation cycle, the spacer after a precharge cycle. A flag reports any captured pair that is illegal for its phase.

Top module: `dr_and_array`

## Requirements
- R1: While rst_n is low, phase_eval, res_valid and rail_err are 0 and every res_t and res_f bit is 0, even when reset is asserted in the middle of an operation.
- R2: After reset is released, phase_eval is 0 in the first cycle and then inverts on every rising clock edge.
- R3: op_a and op_b are sampled only at the rising edge where phase_eval is 0. Values present at an edge where phase_eval is 1 have no effect on any result.
- R4: In the cycle after each evaluation cycle, res_valid is 1 and res_t[i] equals op_a[i] AND op_b[i], using the operands sampled at the edge that started that evaluation.
- R5: In that same valid cycle, res_f[i] is the complement of res_t[i], so each lane shows (1,0) for logic one and (0,1) for logic zero.
- R6: In the cycle after each precharge cycle, res_valid is 0 and every res_t and res_f bit is 0 (the spacer).
- R7: In every valid cycle exactly LANES rails are high across res_t and res_f, and no lane has both rails high. This count is the same for every operand pattern.
- R8: rail_err is 1 exactly when a captured lane pair is (1,1), or when it is (0,0) while res_valid is 1. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_a | input | LANES | Single-rail operand A |
| op_b | input | LANES | Single-rail operand B |
| phase_eval | output | 1 | 1 during an evaluation cycle, 0 during a precharge cycle |
| res_t | output | LANES | Captured true rails |
| res_f | output | LANES | Captured false rails |
| res_valid | output | 1 | Captured rails hold data (1) or the spacer (0) |
| rail_err | output | 1 | An illegal rail code was captured |

## Verification
The AND function is driven with the following operand patterns:
- All zeros and all ones, which separate stuck rails from gating faults.
- One operand held full and the other empty, which shows whether the true rail ignores either input.
- Checkerboard and byte-stripe patterns, which expose swapped or shifted lanes.
- A pair with only the end lanes set, which exposes edge-lane faults.

After every data item the bench looks for the spacer in the following cycle. It also changes the operands during evaluation to confirm that they are not resampled. A reset asserted mid-operation must clear every output at once.

// File: rtl/dr_rail_pkg.sv
package dr_rail_pkg;

  // Dual-rail code: (t,f) = (1,0) one, (0,1) zero, (0,0) spacer, (1,1) illegal
  typedef struct packed {
    logic t;
    logic f;
  } rail_pair_t;

  // Single-rail to rail-pair conversion, masked by the phase enable
  function automatic rail_pair_t rail_encode(input logic v, input logic en);
    rail_pair_t r;
    r.t = v & en;
    r.f = (~v) & en;
    return r;
  endfunction

endpackage

// File: rtl/dr_phase_seq.sv
module dr_phase_seq (
  input  logic clk,
  input  logic rst_n,
  output logic eval_o
);
  logic eval_q;
  logic eval_d;

  always_comb begin
    eval_d = ~eval_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eval_q <= 1'b0;
    else        eval_q <= eval_d;
  end

  assign eval_o = eval_q;

  // R2
  phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_q |=> !eval_q);
  // R2
  phase_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_q |=> eval_q);

endmodule

// File: rtl/dr_operand_stage.sv
module dr_operand_stage
  import dr_rail_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   eval_i,
  input  logic [LANES-1:0]       op_a_i,
  input  logic [LANES-1:0]       op_b_i,
  output logic [LANES-1:0]       a_q_o,
  output logic [LANES-1:0]       b_q_o,
  output rail_pair_t [LANES-1:0] a_rail_o,
  output rail_pair_t [LANES-1:0] b_rail_o
);
  logic             load_en;
  logic [LANES-1:0] a_q, b_q;
  logic [LANES-1:0] a_d, b_d;

  // Load only at the edge that ends a precharge cycle
  assign load_en = ~eval_i;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (load_en) begin
      a_d = op_a_i;
      b_d = op_b_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  // Precharge gating at the first combinational stage
  for (genvar g = 0; g < LANES; g++) begin : g_enc
    assign a_rail_o[g] = rail_encode(a_q[g], eval_i);
    assign b_rail_o[g] = rail_encode(b_q[g], eval_i);
  end

  assign a_q_o = a_q;
  assign b_q_o = b_q;

  // R3
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i |=> ($stable(a_q) && $stable(b_q)));

endmodule

// File: rtl/dr_rail_and.sv
module dr_rail_and
  import dr_rail_pkg::*;
(
  input  rail_pair_t x_i,
  input  rail_pair_t y_i,
  output rail_pair_t z_o
);
  // True rail: AND of true rails. False rail: OR of false rails.
  assign z_o.t = x_i.t & y_i.t;
  assign z_o.f = x_i.f | y_i.f;
endmodule

// File: rtl/dr_capture.sv
module dr_capture
  import dr_rail_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   eval_i,
  input  rail_pair_t [LANES-1:0] lane_i,
  output logic [LANES-1:0]       res_t_o,
  output logic [LANES-1:0]       res_f_o,
  output logic                   valid_o,
  output logic                   err_o
);
  logic [LANES-1:0] t_d, f_d;
  logic [LANES-1:0] t_q, f_q;
  logic             valid_q;
  logic             dual_high;
  logic             empty_in_data;

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign t_d[g] = lane_i[g].t;
    assign f_d[g] = lane_i[g].f;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q     <= '0;
      f_q     <= '0;
      valid_q <= 1'b0;
    end else begin
      t_q     <= t_d;
      f_q     <= f_d;
      valid_q <= eval_i;
    end
  end

  always_comb begin
    dual_high     = |(t_q & f_q);
    empty_in_data = valid_q & (|(~(t_q | f_q)));
  end

  assign err_o   = dual_high | empty_in_data;
  assign res_t_o = t_q;
  assign res_f_o = f_q;
  assign valid_o = valid_q;

  // R6
  spacer_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> ((t_q | f_q) == '0));
  // R7
  one_hot_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ($countones(t_q | f_q) == LANES && (t_q & f_q) == '0));

endmodule

// File: rtl/dr_and_array.sv
module dr_and_array
  import dr_rail_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] op_a,
  input  logic [LANES-1:0] op_b,
  output logic             phase_eval,
  output logic [LANES-1:0] res_t,
  output logic [LANES-1:0] res_f,
  output logic             res_valid,
  output logic             rail_err
);
  logic                   eval_w;
  logic [LANES-1:0]       a_q, b_q;
  rail_pair_t [LANES-1:0] a_rail, b_rail, z_rail;

  dr_phase_seq u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .eval_o (eval_w)
  );

  dr_operand_stage #(.LANES(LANES)) u_ops (
    .clk      (clk),
    .rst_n    (rst_n),
    .eval_i   (eval_w),
    .op_a_i   (op_a),
    .op_b_i   (op_b),
    .a_q_o    (a_q),
    .b_q_o    (b_q),
    .a_rail_o (a_rail),
    .b_rail_o (b_rail)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dr_rail_and u_and (
      .x_i (a_rail[g]),
      .y_i (b_rail[g]),
      .z_o (z_rail[g])
    );
  end

  dr_capture #(.LANES(LANES)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .eval_i  (eval_w),
    .lane_i  (z_rail),
    .res_t_o (res_t),
    .res_f_o (res_f),
    .valid_o (res_valid),
    .err_o   (rail_err)
  );

  assign phase_eval = eval_w;

  // R4
  true_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_t == (a_q & b_q)));
  // R5
  false_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_f == ~(a_q & b_q)));
  // R6
  gate_spacer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_w |-> (z_rail == '0));
  // R8
  rail_err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rail_err);

endmodule

// File: tb/tb_dr_and_array.sv
module tb_dr_and_array;
  localparam int LANES = 32;
  localparam int NVEC  = 8;

  // {op_a, op_b}
  localparam logic [63:0] VEC [NVEC] = '{
    64'h00000000_00000000,
    64'hFFFFFFFF_FFFFFFFF,
    64'hFFFFFFFF_00000000,
    64'h00000000_FFFFFFFF,
    64'h55555555_AAAAAAAA,
    64'h55555555_FFFFFFFF,
    64'h0F0F0F0F_00FF00FF,
    64'h80000001_FFFFFFFF
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LANES-1:0] op_a = '0;
  logic [LANES-1:0] op_b = '0;
  logic             phase_eval;
  logic [LANES-1:0] res_t, res_f;
  logic             res_valid, rail_err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dr_and_array #(.LANES(LANES)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_a       (op_a),
    .op_b       (op_b),
    .phase_eval (phase_eval),
    .res_t      (res_t),
    .res_f      (res_f),
    .res_valid  (res_valid),
    .rail_err   (rail_err)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One operation; if alt, different operands are presented during evaluation
  task automatic run_op(input logic [LANES-1:0] a, input logic [LANES-1:0] b,
                        input bit alt);
    logic [LANES-1:0] exp_t;
    exp_t = a & b;
    while (phase_eval) @(negedge clk);
    op_a = a;
    op_b = b;
    @(negedge clk);
    check(phase_eval == 1'b1, "R2 eval after precharge", 64'(phase_eval), 64'd1);
    if (alt) begin
      op_a = ~a;
      op_b = ~b;
    end
    @(negedge clk);
    check(phase_eval == 1'b0, "R2 precharge after eval", 64'(phase_eval), 64'd0);
    check(res_valid == 1'b1, "R4 valid", 64'(res_valid), 64'd1);
    check(res_t == exp_t, alt ? "R3 ignore eval operands" : "R4 true rail",
          64'(res_t), 64'(exp_t));
    check(res_f == ~exp_t, "R5 false rail", 64'(res_f), 64'(~exp_t));
    check($countones(res_t | res_f) == LANES && (res_t & res_f) == '0,
          "R7 one rail per lane", 64'($countones(res_t | res_f)), 64'(LANES));
    check(rail_err == 1'b0, "R8 no error on data", 64'(rail_err), 64'd0);
    @(negedge clk);
    check(res_valid == 1'b0 && res_t == '0 && res_f == '0,
          "R6 spacer", {res_t, res_f}, 64'd0);
    check(rail_err == 1'b0, "R8 no error on spacer", 64'(rail_err), 64'd0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(phase_eval == 0 && res_valid == 0 && rail_err == 0 &&
          res_t == '0 && res_f == '0, "R1 reset state",
          {res_t, res_f}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(phase_eval == 1'b1, "R2 first toggle", 64'(phase_eval), 64'd1);

    for (int i = 0; i < NVEC; i++) begin
      run_op(VEC[i][63:32], VEC[i][31:0], 1'b0);
    end

    // R3 operands changed during evaluation are not taken
    run_op(32'h12345678, 32'hFEDCBA98, 1'b1);
    run_op(32'hFFFF0000, 32'hF0F0F0F0, 1'b1);

    // R1 mid-operation reset clears outputs at once
    while (phase_eval) @(negedge clk);
    op_a = '1;
    op_b = '1;
    @(negedge clk);
    @(negedge clk);
    check(res_t == '1, "R4 before reset", 64'(res_t), 64'hFFFFFFFF);
    #1 rst_n = 1'b0;
    #0.5;
    check(phase_eval == 0 && res_valid == 0 && res_t == '0 && res_f == '0,
          "R1 async clear", {res_t, res_f}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(phase_eval == 1'b1, "R2 toggle after reset", 64'(phase_eval), 64'd1);
    run_op(32'hA5A5A5A5, 32'h3C3C3C3C, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule